// File: doc/BRIEF.md
# Sequential Long-Operand Adder

This block adds two wide unsigned binary operands of N bits with a single S-bit adder that is reused over K = N/S clock cycles. One slice of each operand is added per cycle, starting at the least significant slice and moving upward. The carry leaving one slice is kept in a single flip-flop and enters the next slice on the following cycle, so the long carry chain of a full-width adder is cut into K short ones.

The caller presents both operands and an input carry on the ports, pulses `start` for one cycle and keeps the operands steady until `done` appears. Each slice result is written into its place in a full-width result register. When the top slice has been written, `done` pulses for one cycle. The sum and the final carry then stay unchanged until the next accepted start. The number of slices is a parameter, and S must divide N exactly.

Top module: `long_add_seq`

## Requirements
- R1: After reset, `z_out` is all zeros and `c_out` and `done` are 0.
- R2: A `start` sampled high while no addition is running begins a new addition. It loads `c_in` as the carry into slice 0 and selects slice 0 on the next cycle.
- R3: When `done` is high, `z_out` equals (x_in + y_in + c_in) mod 2^N, and `c_out` equals bit N of that full sum, including carries that ripple across every slice boundary.
- R4: `done` is 0 on the first K-1 rising edges after the edge that accepted `start`, and it goes high on the K-th such edge.
- R5: `done` stays high for exactly one clock cycle per addition.
- R6: While no addition is running and `start` is low, `z_out` and `c_out` keep their values.
- R7: A `start` pulse that arrives while an addition is running is ignored. A different `c_in` presented with that pulse does not change the result or the cycle in which `done` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins an addition when idle |
| x_in | input | N | First operand, held stable during an addition |
| y_in | input | N | Second operand, held stable during an addition |
| c_in | input | 1 | Input carry into slice 0 |
| z_out | output | N | Full-width sum register |
| c_out | output | 1 | Carry register; holds the final carry out after `done` |
| done | output | 1 | One-cycle pulse when the top slice has been written |

## Verification
Random operand pairs with random input carries check the sum and carry against a full-width reference. They show that slices are placed correctly and that carries cross slice boundaries. All-ones plus zero with an input carry of 1 forces a carry to ripple through every slice and out of the top. All-ones plus all-ones exercises a carry generated in every slice, and zero plus zero shows that no stray carry appears. A start pulse with an inverted input carry in the middle of a run tells an ignored start apart from a restart. The idle cycles after each `done` show that the result is held.

// File: rtl/long_add_seq.sv
module long_add_seq #(
  parameter int N = 64,
  parameter int S = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] x_in,
  input  logic [N-1:0] y_in,
  input  logic         c_in,
  output logic [N-1:0] z_out,
  output logic         c_out,
  output logic         done
);
  localparam int K  = N / S;
  localparam int GW = (K > 1) ? $clog2(K) : 1;
  localparam logic [GW-1:0] LAST = GW'(K - 1);

  if (N % S != 0) begin : g_bad_split
    $error("slice width must divide operand width");
  end

  logic [S-1:0]  x_grp [K];
  logic [S-1:0]  y_grp [K];
  logic [S-1:0]  z_grp [K];
  logic [GW-1:0] grp;
  logic          run;
  logic          carry;
  logic [S:0]    part;

  for (genvar g = 0; g < K; g++) begin : g_slice
    assign x_grp[g] = x_in[g*S +: S];
    assign y_grp[g] = y_in[g*S +: S];
    assign z_out[g*S +: S] = z_grp[g];
  end

  assign part  = {1'b0, x_grp[grp]} + {1'b0, y_grp[grp]} + {{S{1'b0}}, carry};
  assign c_out = carry;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run   <= 1'b0;
      grp   <= '0;
      carry <= 1'b0;
      done  <= 1'b0;
      for (int g = 0; g < K; g++) z_grp[g] <= '0;
    end else begin
      done <= 1'b0;
      if (run) begin
        z_grp[grp] <= part[S-1:0];
        carry      <= part[S];
        if (grp == LAST) begin
          run  <= 1'b0;
          done <= 1'b1;
        end else begin
          grp <= grp + 1'b1;
        end
      end else if (start) begin
        run   <= 1'b1;
        grp   <= '0;
        carry <= c_in;
      end
    end
  end
endmodule

// File: rtl/long_add_seq_chk.sv
module long_add_seq_chk #(
  parameter int N = 64,
  parameter int S = 8
) (
  input logic                                         clk,
  input logic                                         rst_n,
  input logic                                         start,
  input logic                                         run,
  input logic [((N/S) > 1 ? $clog2(N/S) : 1)-1:0]     grp,
  input logic                                         done,
  input logic [N-1:0]                                 z_out,
  input logic                                         c_out
);
  localparam int K  = N / S;
  localparam int GW = (K > 1) ? $clog2(K) : 1;

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !run) |=> (run && grp == '0)); // R2

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (run && grp == GW'(K - 1)) |=> (done && !run)); // R4

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start) |=> ($stable(z_out) && $stable(c_out))); // R6

  AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (run && grp != GW'(K - 1)) |=> (run && grp == GW'($past(grp) + 1'b1))); // R7
endmodule

bind long_add_seq long_add_seq_chk #(.N(N), .S(S)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .run(run), .grp(grp),
  .done(done), .z_out(z_out), .c_out(c_out)
);

// File: tb/sim_long_add_seq.sv
module sim_long_add_seq;
  localparam int N = 64;
  localparam int S = 8;
  localparam int K = N / S;
  localparam time PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [N-1:0] x_in = '0;
  logic [N-1:0] y_in = '0;
  logic         c_in = 1'b0;
  logic [N-1:0] z_out;
  logic         c_out;
  logic         done;

  int checks = 0;
  int fails  = 0;
  int seed_v;

  long_add_seq #(.N(N), .S(S)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .y_in(y_in),
    .c_in(c_in), .z_out(z_out), .c_out(c_out), .done(done)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [N:0] ref_sum(logic [N-1:0] a, logic [N-1:0] b, logic c);
    return {1'b0, a} + {1'b0, b} + {{N{1'b0}}, c};
  endfunction

  function automatic logic [N-1:0] rand_wide();
    logic [N-1:0] r = '0;
    for (int i = 0; i < (N + 31) / 32; i++) r = (r << 32) ^ N'($urandom);
    return r;
  endfunction

  task automatic check(bit ok, string tag, logic [N:0] act, logic [N:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_add(logic [N-1:0] a, logic [N-1:0] b, logic c, bit poke);
    logic [N:0] exp;
    logic [N:0] held;
    exp = ref_sum(a, b, c);
    @(negedge clk);
    x_in = a; y_in = b; c_in = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < K; i++) begin
      if (i > 0) check(done == 1'b0, "R4 done early", N'(done), '0);
      if (poke && i == 2) begin start = 1'b1; c_in = ~c; end
      else begin start = 1'b0; c_in = c; end
      @(negedge clk);
    end
    start = 1'b0; c_in = c;
    check(done == 1'b1, "R4 done on K-th edge", N'(done), 1);
    check({c_out, z_out} == exp, poke ? "R7 result after ignored start" : "R3 sum and carry",
          {c_out, z_out}, exp);
    held = {c_out, z_out};
    @(negedge clk);
    check(done == 1'b0, "R5 done one cycle", N'(done), '0);
    @(negedge clk);
    check({c_out, z_out} == held, "R6 result held", {c_out, z_out}, held);
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    seed_v = $urandom(32'd2718);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(z_out == '0 && c_out == 1'b0 && done == 1'b0, "R1 reset state",
          {c_out, z_out}, '0);
    // R2 and R3 corner cases
    run_add({N{1'b1}}, '0, 1'b1, 1'b0);
    run_add({N{1'b1}}, {N{1'b1}}, 1'b1, 1'b0);
    run_add('0, '0, 1'b0, 1'b0);
    run_add({N{1'b1}}, {N{1'b1}}, 1'b0, 1'b0);
    // R7: mid-run start with the opposite carry
    run_add({N{1'b1}}, '0, 1'b0, 1'b1);
    run_add(rand_wide(), rand_wide(), 1'b1, 1'b1);
    for (int t = 0; t < 24; t++) run_add(rand_wide(), rand_wide(), 1'($urandom), 1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule